// File: doc/BRIEF.md
# Bus Address Decoder with Protection Checking

This block is the central address decoder of a shared, memory-mapped 32-bit system bus. Every cycle in which the bus wait line is low, it samples the transfer type, address, direction, size and protection attributes that the current master presents. It then registers a one-hot slave select for the following data phase. The target slave is found by matching the address against a parameter table of regions. Each region has a base, a mask and three permission flags, and region `i` selects slave line `i`.

The decoder also acts as a bus protection unit. A data transfer is refused when it hits no region, uses the reserved size code, or breaks the permission flags of the region it hits. A refused transfer raises no select, and the decoder itself answers the data phase with an error. Idle cycles and the reserved type code carry no data. The address of such a cycle is still decoded speculatively on a separate combinational output, but no slave is selected, and the decoder completes the cycle itself without error. While reset is held, all selects are low and the decoder owns the response.

Top module: `bus_addr_decoder`

## Requirements
- R1: While `rstN` is low, `slvSel` is all zero, `respOwn` is 1 and `respErr` is 0.
- R2: A data transfer (`tranType` 2'b10 or 2'b11) sampled with `busWait` low that hits region i and is permitted sets `slvSel` to the one-hot value with only bit i set on the next rising edge, with `respOwn` 0 and `respErr` 0; at most one select bit is ever high, and `respOwn` is 1 exactly when no select is high.
- R3: A cycle sampled with `busWait` low whose `tranType` bit 1 is 0 (2'b00 idle or 2'b01 reserved) gives `slvSel` zero, `respOwn` 1 and `respErr` 0 on the next edge.
- R4: `addrMatch` combinationally shows the decoded region as a one-hot vector, whatever the transfer type; the lowest-numbered matching region wins (region i hits when `(addr & MASK_i) == BASE_i`), and the vector is zero when no region hits.
- R5: A data transfer that hits no region gives `slvSel` zero, `respOwn` 1 and `respErr` 1 on the next edge.
- R6: A data transfer with `size` 2'b11 (reserved) is refused with an error, even inside a valid region.
- R7: In a region whose privileged-only flag (flag bit 2) is set, a transfer with `prot[1]` 0 (user) is refused with an error, and one with `prot[1]` 1 (privileged) is granted.
- R8: In a region whose no-execute flag (flag bit 1) is set, a transfer with `prot[0]` 0 (opcode fetch) is refused with an error, and a data access (`prot[0]` 1) is granted.
- R9: In a region whose read-only flag (flag bit 0) is set, a write (`write` 1) is refused with an error, and a read is granted.
- R10: While `busWait` is high, `slvSel`, `respOwn` and `respErr` keep their values, and changes on the transfer inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| tranType | input | 2 | Transfer type: 00 idle, 01 reserved, 10 first/single, 11 burst continuation |
| addr | input | ADDR_W | Transfer address |
| write | input | 1 | 1 write, 0 read |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| prot | input | 2 | Bit 0: 0 opcode fetch / 1 data; bit 1: 0 user / 1 privileged |
| busWait | input | 1 | Bus wait line; low means the previous transfer completed |
| slvSel | output | NUM_SLV | Registered one-hot slave selects for the data phase |
| addrMatch | output | NUM_SLV | Combinational speculative decode of `addr` |
| respOwn | output | 1 | Decoder drives the data-phase response (wait held low) |
| respErr | output | 1 | Error response, valid while `respOwn` is 1 |

## Verification
The bench targets each permission flag with both the refused and the granted attribute combination. A decoder that tested the wrong protection bit, or tested it inverted, would then grant a forbidden access or refuse a legal one. It stretches a data phase with `busWait` high while it changes the address and type underneath. A decoder that re-sampled during wait would switch selects in mid-transfer. Idle and reserved type codes are sent to mapped addresses, so a decoder that selected a slave on a speculative decode would be exposed. A reserved size inside a valid region, and an unmapped address, must each produce the decoder's own error and never a select.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_RSVD = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } tranE;

  localparam logic [1:0] SIZE_RSVD = 2'b11;

  // permission flags of one region; field order is the packed layout
  // used in the REGION_FLAGS parameter: [2] privOnly [1] noExec [0] readOnly
  typedef struct packed {
    logic privOnly;
    logic noExec;
    logic readOnly;
  } regionFlagsT;

  localparam int FLAG_W = $bits(regionFlagsT);

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // previous transfer complete, sample a new one
    logic grant;    // sampled transfer is a permitted data transfer
  } dpStrobeT;

endpackage

// File: rtl/bus_dec_dp.sv
module bus_dec_dp
  import bus_dec_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_MASK = '0,
  parameter logic [NUM_SLV*FLAG_W-1:0] REGION_FLAGS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  dpStrobeT          strobe,
  input  logic              busWait,
  output logic [NUM_SLV-1:0] addrMatch,
  output logic              anyHit,
  output regionFlagsT       hitFlags,
  output logic [NUM_SLV-1:0] slvSel
);

  logic [NUM_SLV-1:0] rawHit;
  logic [NUM_SLV-1:0] selReg;

  // one comparator per region
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLV; gi++) begin : g_region
      localparam logic [ADDR_W-1:0] BASE = REGION_BASE[gi*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] MASK = REGION_MASK[gi*ADDR_W +: ADDR_W];
      assign rawHit[gi] = ((addr & MASK) == BASE);
    end
  endgenerate

  // lowest-numbered region wins
  always_comb begin
    logic found;
    found     = 1'b0;
    addrMatch = '0;
    hitFlags  = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (rawHit[i] && !found) begin
        found        = 1'b1;
        addrMatch[i] = 1'b1;
        hitFlags     = regionFlagsT'(REGION_FLAGS[i*FLAG_W +: FLAG_W]);
      end
    end
    anyHit = found;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (strobe.advance) begin
      selReg <= strobe.grant ? addrMatch : '0;
    end
  end

  assign slvSel = selReg;

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      rst_sel_chk: assert (slvSel == '0)
        else $error("select high during reset");
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slvSel));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWait |=> $stable(slvSel));

endmodule

// File: rtl/bus_dec_ctrl.sv
module bus_dec_ctrl
  import bus_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  tranType,
  input  logic        write,
  input  logic [1:0]  size,
  input  logic [1:0]  prot,
  input  logic        busWait,
  input  logic        anyHit,
  input  regionFlagsT hitFlags,
  output dpStrobeT    strobe,
  output logic        respOwn,
  output logic        respErr
);

  logic isData;
  logic violation;
  logic ownReg;
  logic errReg;

  // bit 1 of the type code alone marks a following data phase
  assign isData = tranType[1];

  always_comb begin
    violation = 1'b0;
    if (!anyHit)                          violation = 1'b1;
    if (size == SIZE_RSVD)                violation = 1'b1;
    if (hitFlags.privOnly && !prot[1])    violation = 1'b1;
    if (hitFlags.noExec   && !prot[0])    violation = 1'b1;
    if (hitFlags.readOnly && write)       violation = 1'b1;
  end

  assign strobe.advance = !busWait;
  assign strobe.grant   = isData && !violation;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownReg <= 1'b1;
      errReg <= 1'b0;
    end else if (strobe.advance) begin
      ownReg <= !strobe.grant;
      errReg <= isData && violation;
    end
  end

  assign respOwn = ownReg;
  assign respErr = errReg;

  // R3
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWait && !tranType[1]) |=> (respOwn && !respErr));

  // R6
  size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWait && tranType[1] && size == SIZE_RSVD) |=> (respOwn && respErr));

  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWait |=> ($stable(respOwn) && $stable(respErr)));

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import bus_dec_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_BASE =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_MASK =
    {32'hF000_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000},
  // per region: [2] privOnly [1] noExec [0] readOnly
  parameter logic [NUM_SLV*FLAG_W-1:0] REGION_FLAGS =
    {3'b100, 3'b010, 3'b001, 3'b000}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         tranType,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               write,
  input  logic [1:0]         size,
  input  logic [1:0]         prot,
  input  logic               busWait,
  output logic [NUM_SLV-1:0] slvSel,
  output logic [NUM_SLV-1:0] addrMatch,
  output logic               respOwn,
  output logic               respErr
);

  dpStrobeT    strobe;
  logic        anyHit;
  regionFlagsT hitFlags;

  bus_dec_dp #(
    .NUM_SLV      (NUM_SLV),
    .ADDR_W       (ADDR_W),
    .REGION_BASE  (REGION_BASE),
    .REGION_MASK  (REGION_MASK),
    .REGION_FLAGS (REGION_FLAGS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .strobe    (strobe),
    .busWait   (busWait),
    .addrMatch (addrMatch),
    .anyHit    (anyHit),
    .hitFlags  (hitFlags),
    .slvSel    (slvSel)
  );

  bus_dec_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tranType (tranType),
    .write    (write),
    .size     (size),
    .prot     (prot),
    .busWait  (busWait),
    .anyHit   (anyHit),
    .hitFlags (hitFlags),
    .strobe   (strobe),
    .respOwn  (respOwn),
    .respErr  (respErr)
  );

  // R2
  own_xor_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    respOwn == !(|slvSel));

  // R5
  miss_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWait && tranType[1] && !(|addrMatch)) |=> (respErr && slvSel == '0));

endmodule

// File: tb/bus_addr_decoder_test.sv
`timescale 1ns/1ps
module bus_addr_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tranType = 2'b00;
  logic [31:0] addr = '0;
  logic        write = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [1:0]  prot = 2'b11;
  logic        busWait = 1'b0;
  logic [3:0]  slvSel;
  logic [3:0]  addrMatch;
  logic        respOwn;
  logic        respErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int       due;
    logic [3:0] sel;
    logic     own;
    logic     err;
    string    tag;
  } expT;

  expT sbq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_addr_decoder uut (
    .clk(clk), .rstN(rstN), .tranType(tranType), .addr(addr),
    .write(write), .size(size), .prot(prot), .busWait(busWait),
    .slvSel(slvSel), .addrMatch(addrMatch), .respOwn(respOwn),
    .respErr(respErr)
  );

  task automatic checkVal(input string tag, input logic [7:0] act,
                          input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present one cycle of bus attributes, predict the result
  task automatic issue(input logic [1:0] t, input logic [31:0] a,
                       input logic w, input logic [1:0] s, input logic [1:0] p,
                       input logic wt, input logic [3:0] eSel,
                       input logic eOwn, input logic eErr, input string tag);
    expT e;
    @(negedge clk);
    tranType = t; addr = a; write = w; size = s; prot = p; busWait = wt;
    e.due = cyc + 1; e.sel = eSel; e.own = eOwn; e.err = eErr; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compare registered outputs one edge after the driven cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        expT e;
        e = sbq.pop_front();
        checkVal({e.tag, " sel"}, {4'b0, slvSel}, {4'b0, e.sel});
        checkVal({e.tag, " own/err"}, {6'b0, respOwn, respErr},
                 {6'b0, e.own, e.err});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, with a legal transfer presented
    tranType = 2'b10; addr = 32'h0000_0010;
    #1;
    checkVal("R1 reset sel", {4'b0, slvSel}, 8'h00);
    checkVal("R1 reset own/err", {6'b0, respOwn, respErr}, 8'h02);
    @(negedge clk);
    rstN = 1'b1;
    tranType = 2'b00;

    // R4 speculative decode, combinational, independent of type
    @(negedge clk);
    addr = 32'h1000_0400; tranType = 2'b00; #1;
    checkVal("R4 match region1", {4'b0, addrMatch}, 8'h02);
    addr = 32'h5000_0000; #1;
    checkVal("R4 no match", {4'b0, addrMatch}, 8'h00);
    addr = 32'h3FFF_FFFC; #1;
    checkVal("R4 match region3", {4'b0, addrMatch}, 8'h08);

    // R2 granted single and burst transfers
    issue(2'b10, 32'h0000_0040, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0001, 1'b0, 1'b0, "R2 nseq region0");
    issue(2'b11, 32'h0000_0044, 1'b1, 2'b00, 2'b01, 1'b0, 4'b0001, 1'b0, 1'b0, "R2 seq region0");
    // R3 idle and reserved type to mapped addresses
    issue(2'b00, 32'h2000_0000, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b0, "R3 idle");
    issue(2'b01, 32'h0000_0000, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b0, "R3 reserved type");
    // R5 unmapped
    issue(2'b10, 32'h8000_0000, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b1, "R5 unmapped");
    // R6 reserved size
    issue(2'b10, 32'h0000_0100, 1'b0, 2'b11, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b1, "R6 size rsvd");
    // R7 privileged-only region 3
    issue(2'b10, 32'h3000_0000, 1'b0, 2'b10, 2'b01, 1'b0, 4'b0000, 1'b1, 1'b1, "R7 user refused");
    issue(2'b10, 32'h3000_0000, 1'b1, 2'b10, 2'b11, 1'b0, 4'b1000, 1'b0, 1'b0, "R7 priv granted");
    // R8 no-execute region 2
    issue(2'b10, 32'h2000_0008, 1'b0, 2'b10, 2'b10, 1'b0, 4'b0000, 1'b1, 1'b1, "R8 fetch refused");
    issue(2'b11, 32'h2000_000C, 1'b0, 2'b10, 2'b01, 1'b0, 4'b0100, 1'b0, 1'b0, "R8 data granted");
    // R9 read-only region 1
    issue(2'b10, 32'h1000_0000, 1'b1, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b1, "R9 write refused");
    issue(2'b10, 32'h1000_0000, 1'b0, 2'b10, 2'b00, 1'b0, 4'b0010, 1'b0, 1'b0, "R9 read granted");
    // R10 wait stretch: inputs change underneath, outputs hold
    issue(2'b00, 32'h8000_0000, 1'b1, 2'b11, 2'b00, 1'b1, 4'b0010, 1'b0, 1'b0, "R10 hold sel 1");
    issue(2'b10, 32'h0000_0000, 1'b0, 2'b10, 2'b11, 1'b1, 4'b0010, 1'b0, 1'b0, "R10 hold sel 2");
    issue(2'b10, 32'h9000_0000, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b1, "R5 after wait");
    issue(2'b10, 32'h0000_0000, 1'b0, 2'b10, 2'b11, 1'b1, 4'b0000, 1'b1, 1'b1, "R10 hold err");
    issue(2'b10, 32'h2000_0000, 1'b0, 2'b01, 2'b11, 1'b0, 4'b0100, 1'b0, 1'b0, "R2 recover");
    issue(2'b00, 32'h0000_0000, 1'b0, 2'b10, 2'b11, 1'b0, 4'b0000, 1'b1, 1'b0, "R3 idle end");

    repeat (3) @(negedge clk);
    checkVal("scoreboard drained", 8'(sbq.size()), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule